// File: doc/BRIEF.md
# Output-Paced Linear Resampler

This block converts a stream of signed samples to a new, unrelated rate. It runs at the output rate, or at an integer multiple of it with a tick strobe marking each output instant. A position accumulator advances by a supplied fixed-point step on every accepted tick. The accumulator counts in units of the input sample period, so its fractional part is directly the interpolation weight and no division is needed.

Each time the accumulator's integer part grows, the block pulls one more input sample through a ready/valid handshake into a two-entry tap pair. Every accepted tick emits one sample, a two-tap linear blend of the pair. The older tap is weighted by one minus the fraction and the newer tap by the fraction. The step comes from an external rate estimator, and the clock-crossing buffers sit outside the block.

The controller has three states. FILL is entered at reset and pulls the first two samples. RUN waits for a tick. FETCH pulls the samples that the last advance made owed. The transitions are:

- FILL→RUN, when the second sample is accepted.
- RUN→FETCH, on a tick whose advance crosses one or more integers.
- RUN→RUN, on a tick with no crossing.
- FETCH→RUN, when the last owed sample is accepted.

Top module: `ots_resampler`

## Requirements
- R1: After reset, out_valid=0, underrun=0, out_data=0 and in_ready=1, with the controller in FILL.
- R2: No output is produced until two input samples have been accepted. A tick during FILL is dropped, and it raises neither out_valid nor underrun.
- R3: A tick sampled while in_ready=0 gives exactly one out_valid pulse in the following cycle, and the position then advances by the step present at that edge. The step is unsigned with FRAC_W=20 fraction bits and INT_W=2 integer bits.
- R4: At any time, the number of accepted input samples equals int(position)+2 once owed samples are fetched. in_ready is 1 exactly while fewer samples than that have been accepted.
- R5: When one advance crosses two or more integers, the owed samples are accepted on consecutive cycles while in_valid stays high. One sample is taken per cycle.
- R6: An emitted value equals floor((x0·(2^20−mu) + x1·mu) / 2^20). Here x0 is the older tap, x1 is the newer tap, and mu is the 20-bit fractional part of the position before the advance. Samples are 14-bit two's complement.
- R7: When mu=0, the output equals the older tap exactly.
- R8: A tick sampled during FETCH is dropped. underrun is 1 for one cycle after it, with out_valid=0, and the position is left unchanged.
- R9: The output never leaves the 14-bit signed range. It always lies between the two taps it was formed from, with clamping at the range limits.
- R10: With step=0, ticks keep emitting, no further samples are pulled, and in_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Working clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Output instant strobe |
| step | input | 22 | Position increment per tick, unsigned, 20 fraction bits |
| in_data | input | 14 | Input sample, signed |
| in_valid | input | 1 | Input sample available |
| in_ready | output | 1 | Block wants a sample this cycle |
| out_data | output | 14 | Interpolated sample, signed |
| out_valid | output | 1 | out_data is new this cycle |
| underrun | output | 1 | A tick was dropped because samples were still owed |

## Verification
On every cycle, the checker confirms several properties. An output pulse always follows a tick. Underrun and output never coincide, and a tick seen with in_ready high never yields an output. Each emitted value lies between its taps, and equals the older tap when the weight was zero.

Only the bench scenarios can show the following:
- the exact blended values;
- that the total number of pulled samples tracks the integer part of the accumulated steps, including multi-crossing advances;
- that stalled ticks leave the position untouched.

// File: rtl/ots_resampler_pkg.sv
package ots_resampler_pkg;
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FETCH = 2'd2
    } ots_state_e;
endpackage

// File: rtl/ots_phase_accum.sv
module ots_phase_accum #(
    parameter int FRAC_W = 20,
    parameter int INT_W  = 2,
    localparam int STEP_W = FRAC_W + INT_W,
    localparam int CRY_W  = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [STEP_W-1:0] step,
    output logic [FRAC_W-1:0] mu,
    output logic [CRY_W-1:0]  carry
);
    logic [FRAC_W-1:0] frac_q;
    logic [STEP_W:0]   sum;

    always_comb begin
        sum   = {{(CRY_W){1'b0}}, frac_q} + {1'b0, step};
        carry = sum[STEP_W:FRAC_W];
        mu    = frac_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (advance) begin
            frac_q <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/ots_lerp.sv
module ots_lerp #(
    parameter int DATA_W = 14,
    parameter int FRAC_W = 20,
    localparam int SUM_W = DATA_W + FRAC_W + 2
) (
    input  logic signed [DATA_W-1:0] tap_old,
    input  logic signed [DATA_W-1:0] tap_new,
    input  logic        [FRAC_W-1:0] mu,
    output logic signed [DATA_W-1:0] result
);
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 <<< (DATA_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(1 <<< (DATA_W-1));

    logic signed [SUM_W-1:0] a_ext, b_ext, w_old, w_new;
    logic signed [SUM_W-1:0] prod_old, prod_new, acc, scaled;

    always_comb begin
        a_ext    = SUM_W'(tap_old);
        b_ext    = SUM_W'(tap_new);
        w_new    = $signed({{(SUM_W-FRAC_W){1'b0}}, mu});
        w_old    = $signed(SUM_W'(1) <<< FRAC_W) - w_new;
        prod_old = a_ext * w_old;
        prod_new = b_ext * w_new;
        acc      = prod_old + prod_new;
        scaled   = acc >>> FRAC_W;
        if (scaled > MAXV) begin
            result = MAXV[DATA_W-1:0];
        end else if (scaled < MINV) begin
            result = MINV[DATA_W-1:0];
        end else begin
            result = scaled[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/ots_seq_ctrl.sv
module ots_seq_ctrl
    import ots_resampler_pkg::*;
#(
    parameter int INT_W = 2,
    localparam int CRY_W = INT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             in_valid,
    input  logic [CRY_W-1:0] carry,
    output logic             in_ready,
    output logic             shift,
    output logic             advance,
    output logic             emit,
    output logic             stall_tick,
    output ots_state_e       state
);
    ots_state_e       state_q, state_d;
    logic [CRY_W-1:0] owe_q, owe_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            owe_q   <= CRY_W'(2);
        end else begin
            state_q <= state_d;
            owe_q   <= owe_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        owe_d      = owe_q;
        in_ready   = 1'b0;
        shift      = 1'b0;
        advance    = 1'b0;
        emit       = 1'b0;
        stall_tick = 1'b0;
        unique case (state_q)
            ST_FILL, ST_FETCH: begin
                in_ready   = 1'b1;
                stall_tick = tick && (state_q == ST_FETCH);
                if (in_valid) begin
                    shift = 1'b1;
                    owe_d = owe_q - CRY_W'(1);
                    if (owe_q == CRY_W'(1)) begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (tick) begin
                    emit    = 1'b1;
                    advance = 1'b1;
                    if (carry != '0) begin
                        owe_d   = carry;
                        state_d = ST_FETCH;
                    end
                end
            end
            default: begin
                state_d = ST_FILL;
                owe_d   = CRY_W'(2);
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/ots_resampler.sv
module ots_resampler
    import ots_resampler_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int FRAC_W = 20,
    parameter int INT_W  = 2,
    localparam int STEP_W = FRAC_W + INT_W,
    localparam int CRY_W  = INT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [STEP_W-1:0]        step,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     in_valid,
    output logic                     in_ready,
    output logic signed [DATA_W-1:0] out_data,
    output logic                     out_valid,
    output logic                     underrun
);
    logic [FRAC_W-1:0]        mu;
    logic [CRY_W-1:0]         carry;
    logic                     shift, advance, emit, stall_tick;
    ots_state_e               state;
    logic signed [DATA_W-1:0] tap_old, tap_new, blend;

    ots_seq_ctrl #(.INT_W(INT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .in_valid   (in_valid),
        .carry      (carry),
        .in_ready   (in_ready),
        .shift      (shift),
        .advance    (advance),
        .emit       (emit),
        .stall_tick (stall_tick),
        .state      (state)
    );

    ots_phase_accum #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .step    (step),
        .mu      (mu),
        .carry   (carry)
    );

    ots_lerp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_lerp (
        .tap_old (tap_old),
        .tap_new (tap_new),
        .mu      (mu),
        .result  (blend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_old <= '0;
            tap_new <= '0;
        end else if (shift) begin
            tap_old <= tap_new;
            tap_new <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            out_valid <= emit;
            underrun  <= stall_tick;
            if (emit) begin
                out_data <= blend;
            end
        end
    end
endmodule

// File: rtl/ots_resampler_chk.sv
module ots_resampler_chk
    import ots_resampler_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int FRAC_W = 20
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic                     underrun,
    input logic signed [DATA_W-1:0] out_data,
    input logic signed [DATA_W-1:0] tap_old,
    input logic signed [DATA_W-1:0] tap_new,
    input logic        [FRAC_W-1:0] mu,
    input ots_state_e               state
);
    assert_fill_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && tick) |=> (!out_valid && !underrun));

    assert_pulse_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(tick));

    assert_ready_blocks_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && in_ready) |=> !out_valid);

    assert_underrun_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !out_valid);

    assert_mu_zero_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mu) == '0) |-> (out_data == $past(tap_old)));

    assert_between_taps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |->
            ((out_data >= $past(tap_old) && out_data <= $past(tap_new)) ||
             (out_data <= $past(tap_old) && out_data >= $past(tap_new))));
endmodule

bind ots_resampler ots_resampler_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .underrun  (underrun),
    .out_data  (out_data),
    .tap_old   (tap_old),
    .tap_new   (tap_new),
    .mu        (mu),
    .state     (state)
);

// File: tb/ots_resampler_bench.sv
module ots_resampler_bench;
    localparam int DATA_W = 14;
    localparam int FRAC_W = 20;
    localparam int STEP_W = 22;
    localparam int NSRC   = 16384;
    localparam longint ONE = longint'(1) << FRAC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [STEP_W-1:0] step = '0;
    logic signed [DATA_W-1:0] in_data = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [DATA_W-1:0] out_data;
    logic out_valid;
    logic underrun;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int     src [NSRC];
    longint pos = 0;
    int     acc = 0;
    int     mu_zero_seen = 0;

    always #2 clk = ~clk;

    ots_resampler u_ots_resampler (
        .clk(clk), .rst_n(rst_n), .tick(tick), .step(step),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .underrun(underrun)
    );

    function automatic longint blend_ref(longint a, longint b, longint m);
        blend_ref = (a * (ONE - m) + b * m) >>> FRAC_W;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, evaluate edge results at next negedge
    task automatic cycle(input bit t, input bit v, input logic [STEP_W-1:0] s);
        bit t_p, r_p, v_p;
        int acc_p;
        longint st_p, m, f, e;
        tick = t; in_valid = v; step = s;
        in_data = DATA_W'(src[acc % NSRC]);
        t_p = t; r_p = in_ready; v_p = v; acc_p = acc; st_p = longint'(s);
        @(negedge clk);
        chk(out_valid == (t_p && !r_p), "R3 out_valid", out_valid, t_p && !r_p);
        chk(underrun == (t_p && r_p && acc_p >= 2), "R8/R2 underrun", underrun,
            t_p && r_p && acc_p >= 2);
        if (t_p && !r_p) begin
            m = pos >>> FRAC_W;
            f = pos & (ONE - 1);
            e = blend_ref(src[m % NSRC], src[(m + 1) % NSRC], f);
            if (f == 0) begin
                mu_zero_seen++;
                chk(out_data == DATA_W'(src[m % NSRC]), "R7 exact tap", out_data, src[m % NSRC]);
            end
            chk(out_data == DATA_W'(e), "R6/R9 value", out_data, e);
            chk(acc_p == m + 2, "R4 pulled count", acc_p, m + 2);
            pos += st_p;
        end
        if (v_p && r_p) acc++;
        chk(in_ready == (acc < (pos >>> FRAC_W) + 2), "R4/R5 in_ready", in_ready,
            acc < (pos >>> FRAC_W) + 2);
    endtask

    task automatic phase(input int n, input int tick_pct, input int valid_pct,
                         input bit rnd_step, input logic [STEP_W-1:0] fixed);
        for (int i = 0; i < n; i++) begin
            logic [STEP_W-1:0] s;
            s = rnd_step ? STEP_W'($urandom_range(32'h3FFFFF)) : fixed;
            cycle($urandom_range(99) < tick_pct, $urandom_range(99) < valid_pct, s);
        end
    endtask

    initial begin
        void'($urandom(32'd24680));
        for (int i = 0; i < NSRC; i++) begin
            if (i < 64) src[i] = (i % 2 == 0) ? 8191 : -8192;
            else src[i] = int'($signed(DATA_W'($urandom)));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(underrun == 1'b0, "R1 underrun", underrun, 0);
        chk(out_data == '0, "R1 out_data", out_data, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        // R2 ticks during fill with no data
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, STEP_W'(ONE));
        // R7 integer step, extremes in taps
        phase(200, 40, 100, 1'b0, STEP_W'(ONE));
        // R6 half step near extremes
        phase(200, 50, 80, 1'b0, STEP_W'(ONE / 2));
        // R5 multiple crossings per tick
        phase(300, 30, 100, 1'b0, STEP_W'(ONE * 5 / 2));
        phase(300, 30, 100, 1'b0, STEP_W'(32'h3FFFFF));
        // R10 zero step: nothing more is pulled
        phase(100, 60, 100, 1'b0, '0);
        chk(in_ready == 1'b0, "R10 no pull", in_ready, 0);
        // random mix
        phase(5000, 50, 70, 1'b1, '0);
        chk(mu_zero_seen > 0, "R7 coverage", mu_zero_seen, 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule